// File: doc/BRIEF.md
# Clock-Jitter Random Seed Generator

This block derives a random seed from the phase wander between the fast system clock and an unrelated slow reference clock. A counter advances on every fast-clock cycle and is never reloaded. The slow clock enters as a plain input and is brought into the fast domain through a synchronizer. Each detected rising edge of the slow clock takes one raw sample, which is bit 0 of the counter at that moment. Five such samples are reduced by a majority vote to one seed bit. The seed register shifts left and takes each new bit into its lowest position.

Software or a boot sequencer raises `start_i` for one cycle. `busy_o` then stays high while 16 bits are collected. When the last bit lands, `busy_o` falls and `done_o` pulses for one cycle. `seed_o` keeps its value until the next start. Both clocks run at fixed rates for the whole generation, and nothing in the block adjusts them. The seed is meant to feed a downstream pseudo-random generator, which lies outside this block.

Top module: `jitter_seed_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `seed_o` is 0. The internal counter is also 0 at reset.
- R2: After reset the counter rises by one on every fast-clock edge and wraps with no reload. Suppose `slow_clk_i` goes high between fast edges E and E+1. Then the raw sample is bit 0 of the counter value held between edges E+2 and E+3, and it is captured at edge E+3.
- R3: Each rising edge of `slow_clk_i` yields exactly one sample, however long the clock stays high. A falling edge or a steady level yields none.
- R4: Each seed bit uses exactly 5 samples. The bit is 1 when 3, 4 or 5 of the samples are 1, and 0 when 0, 1 or 2 are 1. The order of the samples does not matter.
- R5: The seed shifts left and each decided bit enters at bit 0. After the bit at index i is decided, `seed_o` equals the final seed shifted right by i, so the first bit decided ends as bit 15.
- R6: A `start_i` pulse while idle clears the seed, the bit count and the vote counters. On the following cycle `busy_o` is 1 and `seed_o` is 0.
- R7: A `start_i` pulse while `busy_o` is high has no effect. Busy stays high and the final seed is unchanged.
- R8: The capture that completes bit index 0 pulses `done_o` for one cycle, on the same edge on which `busy_o` falls. After that, `seed_o` holds its value, and slow-clock edges that arrive while idle change nothing.
- R9: Asserting `rst` in the middle of a run returns the block to idle with a zero seed. A later run then produces a correct seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Asynchronous slow reference clock, used as data |
| start_i | input | 1 | One-cycle request to begin a generation |
| busy_o | output | 1 | High while a generation is in progress |
| done_o | output | 1 | One-cycle pulse when the seed is complete |
| seed_o | output | 16 | Seed register contents |

## Verification
A sample is captured on the third fast edge after the slow clock rises, and a decided bit or the done pulse appears on that same edge. The bench therefore counts three falling fast edges after each slow-clock rise and samples `seed_o`, `busy_o` and `done_o` there. The bench keeps its own copy of the counter, reset together with the block. It chooses the fast cycle in which to raise the slow clock so that every raw sample takes a value it has planned. A `start_i` pulse shows its effect one edge later, so busy and the cleared seed are read at the next falling edge.

// File: rtl/jsg_pkg.sv
`timescale 1ns/1ps
package jsg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } jsg_state_e;
endpackage

// File: rtl/jsg_edge_sync.sv
`timescale 1ns/1ps
// Brings the slow clock into the fast domain and marks its rising edges.
module jsg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = {sy_q.chain[STAGES-2:0], slow_i};
        sy_d.prev  = sy_q.chain[STAGES-1];
        rise_o     = sy_q.chain[STAGES-1] & ~sy_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '0;
        else     sy_q <= sy_d;
    end

    // A rising edge produces exactly one strobe cycle
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/jsg_free_counter.sv
`timescale 1ns/1ps
// Free-running counter in the fast domain; only its LSB leaves the module.
module jsg_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    output logic lsb_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        lsb_o = cnt_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // Counter steps by one every cycle and wraps
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // LSB toggles each cycle
    assert_lsb_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lsb_o != $past(lsb_o)));
endmodule

// File: rtl/jsg_vote.sv
`timescale 1ns/1ps
// Collects a fixed number of raw samples and decides one bit by majority.
module jsg_vote #(
    parameter int VOTES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic take_i,
    input  logic sample_i,
    output logic decided_o,
    output logic bit_o
);
    localparam int VOTE_W = $clog2(VOTES + 1);
    localparam int THRESH = VOTES / 2 + 1;

    typedef struct packed {
        logic [VOTE_W-1:0] seen;
        logic [VOTE_W-1:0] ones;
    } vote_t;

    vote_t vt_d, vt_q;
    logic [VOTE_W:0] ones_sum;
    logic            last_sample;

    always_comb begin
        vt_d        = vt_q;
        ones_sum    = {1'b0, vt_q.ones} + (VOTE_W+1)'(sample_i);
        last_sample = (vt_q.seen == VOTE_W'(VOTES - 1));
        decided_o   = take_i & last_sample;
        bit_o       = (ones_sum >= (VOTE_W+1)'(THRESH));
        if (clear_i) begin
            vt_d = '0;
        end else if (take_i) begin
            if (last_sample) begin
                vt_d = '0;
            end else begin
                vt_d.seen = vt_q.seen + VOTE_W'(1);
                vt_d.ones = ones_sum[VOTE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vt_q <= '0;
        else     vt_q <= vt_d;
    end

    // Ones can never exceed the number of samples seen so far
    assert_ones_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        vt_q.ones <= vt_q.seen);

    // Sample count stays within one vote window
    assert_window_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        vt_q.seen < VOTE_W'(VOTES));

    // Window restarts after a decision
    assert_window_restart_R4: assert property (@(posedge clk) disable iff (rst)
        decided_o |=> (vt_q.seen == '0 && vt_q.ones == '0));
endmodule

// File: rtl/jitter_seed_gen.sv
`timescale 1ns/1ps
// Top: sequences a generation of SEED_W majority-voted jitter bits.
module jitter_seed_gen
    import jsg_pkg::*;
#(
    parameter int SEED_W      = 16,
    parameter int VOTES       = 5,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SEED_W-1:0] seed_o
);
    localparam int BIT_W = (SEED_W > 1) ? $clog2(SEED_W) : 1;

    typedef struct packed {
        jsg_state_e        state;
        logic [SEED_W-1:0] seed;
        logic [BIT_W-1:0]  bitidx;
        logic              done;
    } top_t;

    top_t tp_d, tp_q;

    logic rise;
    logic raw_bit;
    logic take;
    logic vote_clear;
    logic decided;
    logic voted_bit;

    jsg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .slow_i (slow_clk_i),
        .rise_o (rise)
    );

    jsg_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .lsb_o (raw_bit)
    );

    jsg_vote #(.VOTES(VOTES)) u_vote (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (vote_clear),
        .take_i    (take),
        .sample_i  (raw_bit),
        .decided_o (decided),
        .bit_o     (voted_bit)
    );

    always_comb begin
        tp_d       = tp_q;
        tp_d.done  = 1'b0;
        take       = rise && (tp_q.state == ST_RUN);
        vote_clear = start_i && (tp_q.state == ST_IDLE);
        unique case (tp_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    tp_d.seed   = '0;
                    tp_d.bitidx = '0;
                    tp_d.state  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (decided) begin
                    tp_d.seed = {tp_q.seed[SEED_W-2:0], voted_bit};
                    if (tp_q.bitidx == BIT_W'(SEED_W - 1)) begin
                        tp_d.state = ST_IDLE;
                        tp_d.done  = 1'b1;
                    end else begin
                        tp_d.bitidx = tp_q.bitidx + BIT_W'(1);
                    end
                end
            end
            default: tp_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tp_q <= '{state: ST_IDLE, seed: '0, bitidx: '0, done: 1'b0};
        else     tp_q <= tp_d;
    end

    assign busy_o = (tp_q.state == ST_RUN);
    assign done_o = tp_q.done;
    assign seed_o = tp_q.seed;

    // Start from idle opens a run with a cleared seed
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && seed_o == '0));

    // Start during a run does not end it early
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !decided) |=> busy_o);

    // Done is a single-cycle pulse and coincides with idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // Result holds while idle and not restarted
    assert_seed_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(seed_o));

    // Seed only moves on a decision or a start
    assert_seed_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !decided) |=> $stable(seed_o));

    // Bit index stays within the seed width
    assert_bitidx_range_R5: assert property (@(posedge clk) disable iff (rst)
        tp_q.bitidx <= BIT_W'(SEED_W - 1));
endmodule

// File: tb/sim_jitter_seed_gen.sv
`timescale 1ns/1ps
module sim_jitter_seed_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow = 1'b0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] seed;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 1'b0;
    logic [31:0] edges;   // bench model of the free-running counter

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= '0;
        else     edges <= edges + 32'd1;
    end

    jitter_seed_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .slow_clk_i (slow),
        .start_i    (start),
        .busy_o     (busy),
        .done_o     (done),
        .seed_o     (seed)
    );

    // [18] inject start mid-run, [17:16] sample style, [15:0] target seed
    localparam logic [18:0] VEC [4] = '{
        {1'b0, 2'd0, 16'hA5C3},
        {1'b0, 2'd1, 16'h0000},
        {1'b1, 2'd2, 16'hFFFF},
        {1'b0, 2'd3, 16'h8001}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One slow-clock pulse giving raw sample 'want'; optionally checks the
    // decided-bit state three edges after the rise (R2 capture latency).
    task automatic slow_pulse(input bit want, input int hi_len, input bit chk,
                              input logic [15:0] exp_seed, input bit final_bit);
        repeat (3) step();
        while (edges[0] != want) step();
        slow = 1'b1;
        repeat (3) step();
        if (chk) check(seed == exp_seed, "R2/R4/R5 partial seed", {16'h0, seed}, {16'h0, exp_seed});
        if (final_bit) begin
            check(done == 1'b1, "R8 done pulse", {31'h0, done}, 32'h1);
            check(busy == 1'b0, "R8 busy falls", {31'h0, busy}, 32'h0);
        end
        repeat (hi_len - 3) step();
        slow = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic run_seed(input logic [15:0] target, input int style, input bit inject);
        pulse_start();
        check(busy == 1'b1, "R6 busy after start", {31'h0, busy}, 32'h1);
        check(seed == 16'h0, "R6 seed cleared", {16'h0, seed}, 32'h0);
        for (int i = 15; i >= 0; i--) begin
            int k;
            k = target[i] ? 3 + ((i + style) % 3) : ((i + style) % 3);
            if (inject && i == 8) begin
                pulse_start();
                check(busy == 1'b1, "R7 start ignored while busy", {31'h0, busy}, 32'h1);
            end
            for (int j = 0; j < 5; j++) begin
                bit s;
                s = (style % 2 == 1) ? (j >= 5 - k) : (j < k);
                // R3: high time varies from 3 to 6 cycles, one sample each
                slow_pulse(s, 3 + ((i + j + style) % 4), j == 4,
                           target >> i, (j == 4) && (i == 0));
            end
        end
        step();
        check(done == 1'b0, "R8 done lasts one cycle", {31'h0, done}, 32'h0);
        check(seed == target, "R3/R4/R5 final seed", {16'h0, seed}, {16'h0, target});
    endtask

    initial begin
        // R1 reset state
        repeat (4) step();
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {30'h0, busy, done}, 32'h0);
        check(seed == 16'h0, "R1 reset seed", {16'h0, seed}, 32'h0);
        rst = 1'b0;
        step();
        check(busy == 1'b0 && done == 1'b0 && seed == 16'h0, "R1 after release",
              {14'h0, busy, done, seed}, 32'h0);

        // Vector table
        for (int v = 0; v < 4; v++) begin
            run_seed(VEC[v][15:0], int'(VEC[v][17:16]), VEC[v][18]);
            if (v == 0) begin
                // R8: slow edges while idle leave everything alone
                for (int p = 0; p < 3; p++) slow_pulse(p % 2 == 1, 4, 1'b0, 16'h0, 1'b0);
                repeat (4) step();
                check(seed == VEC[0][15:0], "R8 idle edges ignored", {16'h0, seed}, {16'h0, VEC[0][15:0]});
                check(busy == 1'b0 && done == 1'b0, "R8 idle flags", {30'h0, busy, done}, 32'h0);
            end
        end

        // R9: reset mid-run
        pulse_start();
        for (int j = 0; j < 7; j++) slow_pulse(1'b1, 3, 1'b0, 16'h0, 1'b0);
        check(seed == 16'h1, "R9 partial before reset", {16'h0, seed}, 32'h1);
        rst = 1'b1;
        repeat (2) step();
        check(busy == 1'b0 && done == 1'b0 && seed == 16'h0, "R9 reset mid-run",
              {14'h0, busy, done, seed}, 32'h0);
        rst = 1'b0;
        step();
        run_seed(16'h3C96, 0, 1'b0);   // R9: counters restart cleanly

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule